// File: doc/BRIEF.md
# Direct-Mapped Data Cache with Range Clean and Discard

This block is a small direct-mapped data cache placed between a processor load/store port and a word-addressed memory bus. Another bus master shares that memory and moves data behind the cache's back. Lines are allocated only when a read misses. A runtime mode input selects how write hits are handled. In write-back mode a write hit stays in the cache and marks the line dirty. In write-through mode a write hit also goes to memory at once.

Software keeps the cache coherent with the other master through two range commands. Each command takes a byte start address and a byte length, and works on whole 32-byte lines. The clean command writes a dirty line to memory and then frees it. The discard command frees a line and writes nothing. Ranges are widened to line boundaries. A discard therefore also drops modified words that share a line with the range. Software either aligns the buffers it shares with the other master, or it cleans the destination before the transfer instead of discarding it afterwards.

Top module: `wbcache`

## Requirements
- R1: A read miss fetches the whole 32-byte line as 8 word beats in ascending word-address order and returns the requested word. Later reads of that line complete with no memory traffic.
- R2: A write miss performs exactly one memory word write and allocates no line, so a later read of the same address still needs a line fetch.
- R3: With `wt_mode`=0, a write hit updates only the cached word. Memory keeps its old value and the line becomes dirty.
- R4: With `wt_mode`=1, every write is acknowledged in the same cycle as its single memory write to the same word address with the same data. A write hit also updates the cached word, and a later clean of that line writes nothing.
- R5: A clean command (`mnt_op`=0) writes each dirty line in the range back as 8 ascending beats and then invalidates it. Clean lines in the range are invalidated without memory traffic.
- R6: A discard command (`mnt_op`=1) invalidates each cached line in the range and never writes memory, so dirty data in those lines is lost.
- R7: A range command acts on every line from the line holding `mnt_addr` through the line holding byte `mnt_addr+mnt_len-1`. This includes bytes of those lines outside the range. Lines outside that span are untouched.
- R8: A range command with `mnt_len`=0 raises `mnt_done` in the cycle after acceptance and affects no line.
- R9: Memory writes made by the other master are not seen by cached lines. A read hit returns the cached copy until the line is cleaned or discarded.
- R10: While `mem_req` is high and `mem_ready` is low, `mem_addr`, `mem_we` and `mem_wdata` stay unchanged in the next cycle.
- R11: `cpu_ready` is never high while `mnt_busy` is high. `mnt_done` is a single-cycle pulse inside the busy period.
- R12: A read miss whose line slot holds a dirty line from another address first writes that line back as 8 ascending beats, then fetches the new line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; all lines become invalid |
| wt_mode | input | 1 | 1 = write-through, 0 = write-back |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = word write, 0 = word read |
| cpu_addr | input | 16 | Processor byte address (word aligned) |
| cpu_wdata | input | 32 | Write data |
| cpu_ready | output | 1 | Request completes at this clock edge |
| cpu_rdata | output | 32 | Read data, valid with `cpu_ready` on a read |
| mnt_req | input | 1 | Range command request, held until `mnt_done` |
| mnt_op | input | 1 | 0 = clean and free, 1 = discard |
| mnt_addr | input | 16 | Range start byte address |
| mnt_len | input | 16 | Range length in bytes |
| mnt_busy | output | 1 | Range command in progress |
| mnt_done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory beat valid |
| mem_we | output | 1 | Memory beat is a write |
| mem_addr | output | 14 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory accepts the beat (read data valid) this cycle |
| mem_rdata | input | 32 | Memory read data |

## Verification
The properties assume that the processor keeps `cpu_req`, `cpu_we`, `cpu_addr` and `cpu_wdata` steady until `cpu_ready`. They also assume that `mnt_req` and its operands stay steady until `mnt_done`, and that `mem_rdata` is valid whenever `mem_ready` is high during a read beat. The stimulus changes request inputs only on falling edges, and only after the matching completion has been seen. The memory model drops `mem_ready` on every third cycle, so handshake holds and stalled beats occur in every burst. The other master's writes go straight into the memory model and never go through the cache ports.

// File: rtl/wbc_pkg.sv
`timescale 1ns/1ps
package wbc_pkg;
    parameter int ADDR_W     = 16;
    parameter int DATA_W     = 32;
    parameter int LINE_BYTES = 32;
    parameter int NUM_LINES  = 16;

    localparam int BOFF_W  = $clog2(DATA_W / 8);
    localparam int OFF_W   = $clog2(LINE_BYTES);
    localparam int WORDS   = LINE_BYTES / (DATA_W / 8);
    localparam int WSEL_W  = $clog2(WORDS);
    localparam int IDX_W   = $clog2(NUM_LINES);
    localparam int TAG_W   = ADDR_W - OFF_W - IDX_W;
    localparam int LADDR_W = ADDR_W - OFF_W;
    localparam int WADDR_W = ADDR_W - BOFF_W;

    typedef struct packed {
        logic             valid;
        logic             dirty;
        logic [TAG_W-1:0] tag;
    } meta_t;

    typedef enum logic [2:0] {
        S_IDLE, S_VICT, S_FILL, S_WRMEM, S_MLINE, S_MWB, S_MDONE
    } st_e;

    typedef enum logic {OP_CLEAN = 1'b0, OP_DISCARD = 1'b1} mop_e;

    function automatic logic [LADDR_W-1:0] line_of(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:OFF_W];
    endfunction
endpackage

// File: rtl/wbc_store.sv
`timescale 1ns/1ps
module wbc_store
    import wbc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [WSEL_W-1:0] rd_word,
    output meta_t             rd_meta,
    output logic [DATA_W-1:0] rd_data,
    input  logic              dw_en,
    input  logic [IDX_W-1:0]  dw_idx,
    input  logic [WSEL_W-1:0] dw_word,
    input  logic [DATA_W-1:0] dw_data,
    input  logic              mw_en,
    input  logic [IDX_W-1:0]  mw_idx,
    input  meta_t             mw_meta
);
    meta_t             meta_q [NUM_LINES];
    logic [DATA_W-1:0] data_q [NUM_LINES*WORDS];

    // one tag/state register per line slot
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst)
                meta_q[g] <= '0;
            else if (mw_en && mw_idx == IDX_W'(g))
                meta_q[g] <= mw_meta;
        end
    end

    always_ff @(posedge clk) begin
        if (dw_en)
            data_q[{dw_idx, dw_word}] <= dw_data;
    end

    assign rd_meta = meta_q[rd_idx];
    assign rd_data = data_q[{rd_idx, rd_word}];
endmodule

// File: rtl/wbc_range.sv
`timescale 1ns/1ps
module wbc_range
    import wbc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic               step,
    input  logic [ADDR_W-1:0]  base,
    input  logic [ADDR_W-1:0]  len,
    output logic [LADDR_W-1:0] cur,
    output logic               at_end,
    output logic               none
);
    logic [LADDR_W-1:0] last_q;
    logic [ADDR_W-1:0]  end_byte;

    assign end_byte = base + len - 1'b1;
    assign none     = (len == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur    <= '0;
            last_q <= '0;
        end else if (load) begin
            cur    <= line_of(base);
            last_q <= line_of(end_byte);
        end else if (step) begin
            cur    <= cur + 1'b1;
        end
    end

    assign at_end = (cur == last_q);
endmodule

// File: rtl/wbcache.sv
`timescale 1ns/1ps
module wbcache
    import wbc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wt_mode,
    input  logic               cpu_req,
    input  logic               cpu_we,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic [DATA_W-1:0]  cpu_wdata,
    output logic               cpu_ready,
    output logic [DATA_W-1:0]  cpu_rdata,
    input  logic               mnt_req,
    input  logic               mnt_op,
    input  logic [ADDR_W-1:0]  mnt_addr,
    input  logic [ADDR_W-1:0]  mnt_len,
    output logic               mnt_busy,
    output logic               mnt_done,
    output logic               mem_req,
    output logic               mem_we,
    output logic [WADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0]  mem_wdata,
    input  logic               mem_ready,
    input  logic [DATA_W-1:0]  mem_rdata
);
    st_e                st_q, nxt;
    logic [WSEL_W-1:0]  beat_q;
    logic               beat_inc, advance;

    logic [IDX_W-1:0]   cpu_idx, mnt_idx, rd_idx, mw_idx;
    logic [TAG_W-1:0]   cpu_tag, mnt_tag, cmp_tag;
    logic [WSEL_W-1:0]  cpu_wsel, rd_word, dw_word;
    logic [DATA_W-1:0]  rd_data, dw_data;
    meta_t              rd_meta, mw_meta;
    logic               dw_en, mw_en, hit, maint, last_beat;
    logic               rng_load, rng_step, rng_end, rng_none;
    logic [LADDR_W-1:0] rng_cur;
    logic               unused_boff;

    assign unused_boff = ^cpu_addr[BOFF_W-1:0];
    assign cpu_idx     = cpu_addr[OFF_W+IDX_W-1:OFF_W];
    assign cpu_tag     = cpu_addr[ADDR_W-1:OFF_W+IDX_W];
    assign cpu_wsel    = cpu_addr[OFF_W-1:BOFF_W];
    assign mnt_idx     = rng_cur[IDX_W-1:0];
    assign mnt_tag     = rng_cur[LADDR_W-1:IDX_W];

    assign maint     = (st_q == S_MLINE) || (st_q == S_MWB) || (st_q == S_MDONE);
    assign rd_idx    = maint ? mnt_idx : cpu_idx;
    assign mw_idx    = rd_idx;
    assign rd_word   = (st_q == S_VICT || st_q == S_MWB) ? beat_q : cpu_wsel;
    assign cmp_tag   = maint ? mnt_tag : cpu_tag;
    assign hit       = rd_meta.valid && (rd_meta.tag == cmp_tag);
    assign last_beat = (beat_q == WSEL_W'(WORDS - 1));
    assign mnt_busy  = maint;
    assign mnt_done  = (st_q == S_MDONE);
    assign cpu_rdata = rd_data;

    wbc_store i_store (
        .clk(clk), .rst(rst),
        .rd_idx(rd_idx), .rd_word(rd_word), .rd_meta(rd_meta), .rd_data(rd_data),
        .dw_en(dw_en), .dw_idx(cpu_idx), .dw_word(dw_word), .dw_data(dw_data),
        .mw_en(mw_en), .mw_idx(mw_idx), .mw_meta(mw_meta)
    );

    wbc_range i_range (
        .clk(clk), .rst(rst), .load(rng_load), .step(rng_step),
        .base(mnt_addr), .len(mnt_len),
        .cur(rng_cur), .at_end(rng_end), .none(rng_none)
    );

    always_comb begin
        nxt       = st_q;
        beat_inc  = 1'b0;
        advance   = 1'b0;
        cpu_ready = 1'b0;
        dw_en     = 1'b0;
        dw_word   = cpu_wsel;
        dw_data   = cpu_wdata;
        mw_en     = 1'b0;
        mw_meta   = '0;
        rng_load  = 1'b0;
        rng_step  = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = cpu_addr[ADDR_W-1:BOFF_W];
        mem_wdata = cpu_wdata;
        case (st_q)
            S_IDLE: begin
                if (mnt_req) begin
                    rng_load = 1'b1;
                    nxt      = rng_none ? S_MDONE : S_MLINE;
                end else if (cpu_req) begin
                    if (!cpu_we) begin
                        if (hit)
                            cpu_ready = 1'b1;
                        else
                            nxt = (rd_meta.valid && rd_meta.dirty) ? S_VICT : S_FILL;
                    end else if (hit && !wt_mode) begin
                        cpu_ready     = 1'b1;
                        dw_en         = 1'b1;
                        mw_en         = 1'b1;
                        mw_meta.valid = 1'b1;
                        mw_meta.dirty = 1'b1;
                        mw_meta.tag   = cpu_tag;
                    end else begin
                        nxt = S_WRMEM;
                    end
                end
            end
            S_VICT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {rd_meta.tag, cpu_idx, beat_q};
                mem_wdata = rd_data;
                if (mem_ready) begin
                    beat_inc = 1'b1;
                    if (last_beat) nxt = S_FILL;
                end
            end
            S_FILL: begin
                mem_req  = 1'b1;
                mem_addr = {cpu_tag, cpu_idx, beat_q};
                dw_word  = beat_q;
                dw_data  = mem_rdata;
                if (mem_ready) begin
                    dw_en    = 1'b1;
                    beat_inc = 1'b1;
                    if (last_beat) begin
                        mw_en         = 1'b1;
                        mw_meta.valid = 1'b1;
                        mw_meta.tag   = cpu_tag;
                        nxt           = S_IDLE;
                    end
                end
            end
            S_WRMEM: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                if (mem_ready) begin
                    cpu_ready = 1'b1;
                    dw_en     = hit;
                    nxt       = S_IDLE;
                end
            end
            S_MLINE: begin
                if (hit && mnt_op == OP_CLEAN && rd_meta.dirty) begin
                    nxt = S_MWB;
                end else begin
                    mw_en   = hit;
                    advance = 1'b1;
                end
            end
            S_MWB: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {rd_meta.tag, mnt_idx, beat_q};
                mem_wdata = rd_data;
                if (mem_ready) begin
                    beat_inc = 1'b1;
                    if (last_beat) begin
                        mw_en   = 1'b1;
                        advance = 1'b1;
                    end
                end
            end
            S_MDONE: nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
        if (advance) begin
            if (rng_end) begin
                nxt = S_MDONE;
            end else begin
                rng_step = 1'b1;
                nxt      = S_MLINE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= S_IDLE;
            beat_q <= '0;
        end else begin
            st_q <= nxt;
            if (beat_inc) beat_q <= beat_q + 1'b1;
        end
    end
endmodule

// File: rtl/wbc_chk.sv
`timescale 1ns/1ps
module wbc_chk
    import wbc_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               wt_mode,
    input logic               cpu_req,
    input logic               cpu_we,
    input logic [ADDR_W-1:0]  cpu_addr,
    input logic [DATA_W-1:0]  cpu_wdata,
    input logic               cpu_ready,
    input logic               mnt_busy,
    input logic               mnt_done,
    input logic               mem_req,
    input logic               mem_we,
    input logic [WADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0]  mem_wdata,
    input logic               mem_ready
);
    // R10
    mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

    // R1
    fill_order_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_we && mem_ready && (mem_addr[WSEL_W-1:0] != '1)
        |=> mem_req && !mem_we && (mem_addr == $past(mem_addr) + 1'b1));

    // R4
    wt_write_chk: assert property (@(posedge clk) disable iff (rst)
        wt_mode && cpu_req && cpu_we && cpu_ready
        |-> mem_req && mem_we && mem_ready && (mem_addr == cpu_addr[ADDR_W-1:BOFF_W]) && (mem_wdata == cpu_wdata));

    // R11
    stall_chk: assert property (@(posedge clk) disable iff (rst)
        !(cpu_ready && mnt_busy));

    // R11
    done_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
        mnt_done |-> mnt_busy);

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        mnt_done |=> !mnt_done);
endmodule

bind wbcache wbc_chk i_chk (
    .clk(clk), .rst(rst), .wt_mode(wt_mode), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
    .mnt_busy(mnt_busy), .mnt_done(mnt_done), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready)
);

// File: tb/test_wbcache.sv
`timescale 1ns/1ps
module test_wbcache;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wt_mode = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic        cpu_ready;
    logic [31:0] cpu_rdata;
    logic        mnt_req = 1'b0, mnt_op = 1'b0;
    logic [15:0] mnt_addr = '0, mnt_len = '0;
    logic        mnt_busy, mnt_done;
    logic        mem_req, mem_we;
    logic [13:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ready = 1'b0;
    logic [31:0] mem_rdata = '0;

    int n_tests = 0, n_fail = 0;
    int n_rd = 0, n_wr = 0, hold_err = 0, rcnt = 0;
    logic [31:0] mem_q [int];

    always #4 clk = ~clk;

    wbcache i_wbcache (.*);

    function automatic logic [31:0] mem_rd(input int a);
        return mem_q.exists(a) ? mem_q[a] : (32'hA000_0000 | 32'(a));
    endfunction

    // memory model: stalls one cycle in three
    always @(negedge clk) begin
        rcnt      <= rcnt + 1;
        mem_ready <= (rcnt % 3) != 2;
        mem_rdata <= mem_rd(int'(mem_addr));
    end

    logic        pend = 1'b0, p_we = 1'b0;
    logic [13:0] p_addr = '0;
    logic [31:0] p_wd = '0;
    always @(posedge clk) begin
        if (!rst) begin
            if (pend && !(mem_req && mem_addr == p_addr && mem_we == p_we && (!p_we || mem_wdata == p_wd)))
                hold_err++;
            pend   = mem_req && !mem_ready;
            p_addr = mem_addr;
            p_we   = mem_we;
            p_wd   = mem_wdata;
            if (mem_req && mem_ready) begin
                if (mem_we) begin
                    mem_q[int'(mem_addr)] = mem_wdata;
                    n_wr++;
                end else begin
                    n_rd++;
                end
            end
        end
    end

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", r, act, exp);
        end
    endtask

    task automatic cpu_rd(input logic [15:0] a, output logic [31:0] d);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = a;
        #1;
        while (!cpu_ready) begin @(negedge clk); #1; end
        d = cpu_rdata;
        @(negedge clk);
        cpu_req = 1'b0;
    endtask

    task automatic cpu_wr(input logic [15:0] a, input logic [31:0] v);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = v;
        #1;
        while (!cpu_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        cpu_req = 1'b0; cpu_we = 1'b0;
    endtask

    task automatic mnt(input logic op, input logic [15:0] a, input logic [15:0] l, output int cyc);
        @(negedge clk);
        mnt_req = 1'b1; mnt_op = op; mnt_addr = a; mnt_len = l;
        cyc = 0;
        do begin @(negedge clk); cyc++; end while (!mnt_done);
        mnt_req = 1'b0;
    endtask

    task automatic t_reset();
        chk("R11 reset busy", 32'(mnt_busy), 0);
        chk("R11 reset done", 32'(mnt_done), 0);
        chk("R1 reset mem_req", 32'(mem_req), 0);
        chk("R1 reset cpu_ready", 32'(cpu_ready), 0);
    endtask

    task automatic t_read_alloc();
        logic [31:0] d; int r0;
        r0 = n_rd;
        cpu_rd(16'h0104, d);
        chk("R1 miss data", d, 32'hA000_0041);
        chk("R1 fill beats", 32'(n_rd - r0), 8);
        r0 = n_rd;
        cpu_rd(16'h0108, d);
        chk("R1 hit data", d, 32'hA000_0042);
        chk("R1 hit no traffic", 32'(n_rd - r0), 0);
    endtask

    task automatic t_write_miss();
        logic [31:0] d; int w0, r0;
        w0 = n_wr;
        cpu_wr(16'h0200, 32'h1111_1111);
        chk("R2 single write", 32'(n_wr - w0), 1);
        chk("R2 memory value", mem_rd(32'h80), 32'h1111_1111);
        r0 = n_rd;
        cpu_rd(16'h0200, d);
        chk("R2 no allocate", 32'(n_rd - r0), 8);
        chk("R2 read data", d, 32'h1111_1111);
    endtask

    task automatic t_wb_hit();
        logic [31:0] d; int w0;
        w0 = n_wr;
        cpu_wr(16'h0104, 32'h2222_2222);
        chk("R3 no mem write", 32'(n_wr - w0), 0);
        chk("R3 mem unchanged", mem_rd(32'h41), 32'hA000_0041);
        cpu_rd(16'h0104, d);
        chk("R3 cached value", d, 32'h2222_2222);
    endtask

    task automatic t_clean();
        logic [31:0] d; int w0, r0, c;
        w0 = n_wr;
        mnt(1'b0, 16'h0104, 16'd4, c);
        chk("R5 writeback beats", 32'(n_wr - w0), 8);
        chk("R5 memory updated", mem_rd(32'h41), 32'h2222_2222);
        r0 = n_rd;
        cpu_rd(16'h0104, d);
        chk("R5 line freed", 32'(n_rd - r0), 8);
        chk("R5 refetched value", d, 32'h2222_2222);
    endtask

    task automatic t_discard();
        logic [31:0] d; int w0, c;
        cpu_rd(16'h0300, d);
        cpu_wr(16'h031C, 32'h3333_3333);
        cpu_wr(16'h0300, 32'h4444_4444);
        w0 = n_wr;
        mnt(1'b1, 16'h0300, 16'd4, c);
        chk("R6 no writeback", 32'(n_wr - w0), 0);
        cpu_rd(16'h031C, d);
        chk("R6 R7 neighbour lost", d, 32'hA000_00C7);
        chk("R6 memory untouched", mem_rd(32'hC7), 32'hA000_00C7);
    endtask

    task automatic t_span();
        logic [31:0] d; int w0, c;
        for (int i = 0; i < 4; i++) begin
            cpu_rd(16'(16'h0400 + i * 32), d);
            cpu_wr(16'(16'h0400 + i * 32), 32'h0000_0AA0 + 32'(i));
        end
        w0 = n_wr;
        mnt(1'b0, 16'h043C, 16'd8, c);
        chk("R7 two lines cleaned", 32'(n_wr - w0), 16);
        chk("R7 first line", mem_rd(32'h108), 32'h0000_0AA1);
        chk("R7 last line", mem_rd(32'h110), 32'h0000_0AA2);
        chk("R7 below span", mem_rd(32'h100), 32'hA000_0100);
        chk("R7 above span", mem_rd(32'h118), 32'hA000_0118);
    endtask

    task automatic t_zero_len();
        logic [31:0] d; int w0, r0, c;
        w0 = n_wr;
        mnt(1'b0, 16'h0460, 16'd0, c);
        chk("R8 one cycle", 32'(c), 1);
        chk("R8 no writeback", 32'(n_wr - w0), 0);
        r0 = n_rd;
        cpu_rd(16'h0460, d);
        chk("R8 line kept", 32'(n_rd - r0), 0);
        chk("R8 dirty data kept", d, 32'h0000_0AA3);
    endtask

    task automatic t_write_through();
        logic [31:0] d; int w0, r0, c;
        wt_mode = 1'b1;
        cpu_rd(16'h0500, d);
        w0 = n_wr;
        cpu_wr(16'h0500, 32'h5555_5555);
        chk("R4 memory write", 32'(n_wr - w0), 1);
        chk("R4 memory value", mem_rd(32'h140), 32'h5555_5555);
        r0 = n_rd;
        cpu_rd(16'h0500, d);
        chk("R4 cached value", d, 32'h5555_5555);
        chk("R4 hit no traffic", 32'(n_rd - r0), 0);
        w0 = n_wr;
        mnt(1'b0, 16'h0500, 16'd32, c);
        chk("R4 line not dirty", 32'(n_wr - w0), 0);
        wt_mode = 1'b0;
    endtask

    task automatic t_other_master();
        logic [31:0] d; int r0, c;
        cpu_rd(16'h0620, d);
        @(negedge clk);
        mem_q[32'h188] = 32'h6666_6666;
        r0 = n_rd;
        cpu_rd(16'h0620, d);
        chk("R9 stale copy", d, 32'hA000_0188);
        chk("R9 no traffic", 32'(n_rd - r0), 0);
        mnt(1'b1, 16'h0620, 16'd4, c);
        cpu_rd(16'h0620, d);
        chk("R9 new data after discard", d, 32'h6666_6666);
    endtask

    task automatic t_victim();
        logic [31:0] d; int w0, r0;
        w0 = n_wr; r0 = n_rd;
        cpu_rd(16'h0600, d);
        chk("R12 victim beats", 32'(n_wr - w0), 8);
        chk("R12 fill beats", 32'(n_rd - r0), 8);
        chk("R12 victim in memory", mem_rd(32'h100), 32'h0000_0AA0);
        chk("R12 new data", d, 32'hA000_0180);
    endtask

    task automatic t_stall();
        logic [31:0] d; int w0, ov, busy_seen;
        cpu_rd(16'h0A40, d);
        cpu_wr(16'h0A40, 32'hBBBB_BBBB);
        w0 = n_wr; ov = 0; busy_seen = 0;
        @(negedge clk);
        mnt_req = 1'b1; mnt_op = 1'b0; mnt_addr = 16'h0A40; mnt_len = 16'd4;
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 16'h0A44;
        forever begin
            @(negedge clk); #1;
            if (cpu_ready && mnt_busy) ov++;
            if (mnt_busy) busy_seen++;
            if (mnt_done) break;
        end
        mnt_req = 1'b0;
        while (!cpu_ready) begin @(negedge clk); #1; end
        d = cpu_rdata;
        @(negedge clk);
        cpu_req = 1'b0;
        chk("R11 no ack while busy", 32'(ov), 0);
        chk("R11 busy seen", 32'(busy_seen > 8), 1);
        chk("R11 clean beats", 32'(n_wr - w0), 8);
        chk("R11 read after clean", d, 32'hA000_0291);
        chk("R10 handshake hold", 32'(hold_err), 0);
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #1;
        t_reset();
        t_read_alloc();
        t_write_miss();
        t_wb_hit();
        t_clean();
        t_discard();
        t_span();
        t_zero_len();
        t_write_through();
        t_other_master();
        t_victim();
        t_stall();
        finish_run();
    end
endmodule